// File: doc/BRIEF.md
# I2C Slave Address Comparator

This block sits beside an I2C bit engine and judges the first byte that follows every START or repeated START. The bit engine shifts in SDA and hands over each finished byte with a one-cycle strobe. It also flags each START it sees. From the first byte of a transfer, the comparator decides two things. The first is whether the local slave is being called by its programmed 7-bit address. The second is whether the byte is the general broadcast address, which calls every slave at once.

A direct hit or a broadcast call sets a sticky "addressed" flag and fires a one-cycle interrupt pulse. It also fires a one-cycle ACK request that tells the bit engine to pull SDA low during the acknowledge bit, and it latches the R/W bit of the call. Broadcast reception has its own sticky flag. That flag is set even while the local unit is itself the bus master, so a master can tell that its own call was a broadcast. Both flags are cleared by write-one-to-clear inputs. When the block is enabled in the middle of a transfer, it ignores that transfer and starts comparing only after the next START.

Top module: `i2c_addr_cmp`

## Requirements
- R1: On a compare, the address field is rx_byte[7:1] (first bit on the wire in bit 7) and rx_byte[0] is R/W. If the field equals own_addr, `addressed` is high from the clock edge that samples the byte_done strobe onward.
- R2: A first byte of exactly 0x00 (address 0, R/W 0) sets `bcast_rcvd` and also counts as addressing the slave. A byte of 0x01 (address 0 with R/W 1) is not a broadcast.
- R3: `addressed` and `bcast_rcvd` stay set until their clear inputs (clr_addr, clr_bcast) are high at a clock edge. If a set and a clear land on the same edge, the set wins.
- R4: `irq` and `ack_req` are high for exactly the one cycle that follows the edge at which the compare hit, and they are low at every other time.
- R5: `rw_bit` takes rx_byte[0] of the byte that addressed the slave and holds it until the slave is addressed again.
- R6: While enable is low, no compare happens. After enable rises, bytes are ignored until a start_det strobe has been seen.
- R7: Only the first byte_done after a START or repeated START is compared; later bytes of the transfer are ignored. A byte_done that arrives in the same cycle as start_det is not compared.
- R8: While self_master is high during the compare, a broadcast byte still sets `bcast_rcvd`, but nothing sets `addressed`, `irq`, `ack_req` or `rw_bit`.
- R9: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Comparator enable |
| self_master | input | 1 | Local unit currently owns the bus as master |
| start_det | input | 1 | One-cycle strobe on START or repeated START |
| byte_done | input | 1 | One-cycle strobe when rx_byte holds a complete byte |
| rx_byte | input | 8 | Received byte, bit 7 first on the wire, bit 0 is R/W |
| own_addr | input | 7 | Programmed slave address |
| clr_addr | input | 1 | Write-one-to-clear for addressed |
| clr_bcast | input | 1 | Write-one-to-clear for bcast_rcvd |
| addressed | output | 1 | Sticky: slave was addressed directly or by broadcast |
| bcast_rcvd | output | 1 | Sticky: broadcast address seen on the bus |
| irq | output | 1 | One-cycle interrupt pulse on being addressed |
| ack_req | output | 1 | One-cycle request to acknowledge the address byte |
| rw_bit | output | 1 | R/W bit of the last addressing byte |

## Verification
The assertions check every cycle that interrupt and ACK pulses last a single cycle. They check that no pulse follows a cycle with the comparator disabled or with the local unit mastering, that the addressed flag stays set until cleared, and that only one compare happens per START. The bench scenarios are needed for the rest. These are whether the right byte is chosen for comparison, the exact broadcast encoding against 0x01, how the block joins a transfer already in progress, what happens when START and byte strobes collide, and which wins when set and clear coincide. They also cover latching of the R/W bit.

// File: rtl/i2c_acmp_pkg.sv
package i2c_acmp_pkg;
  // Position within the current transfer, as seen by the comparator
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,  // not armed: disabled, or waiting for a START
    SEQ_ARMED = 2'd1,  // START seen, next byte is the address byte
    SEQ_DATA  = 2'd2   // address byte consumed, ignore the rest
  } acmp_seq_e;

  typedef struct packed {
    logic own_hit;
    logic bcast_hit;
    logic rw;
  } acmp_match_t;
endpackage

// File: rtl/i2c_acmp_rstsync.sv
module i2c_acmp_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_acmp_seq.sv
module i2c_acmp_seq
  import i2c_acmp_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic start_i,
  input  logic byte_done_i,
  output logic cmp_o
);
  acmp_seq_e state_q;
  acmp_seq_e state_d;

  // the address byte is the first byte strobe seen while armed
  always_comb begin
    cmp_o = enable_i && (state_q == SEQ_ARMED) && byte_done_i && !start_i;
  end

  always_comb begin
    state_d = state_q;
    if (!enable_i) begin
      state_d = SEQ_IDLE;
    end else if (start_i) begin
      state_d = SEQ_ARMED;
    end else if (state_q == SEQ_ARMED && byte_done_i) begin
      state_d = SEQ_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  // R7: no two compares back to back without a new START in between
  assert_one_cmp_per_start_R7 : assert property (@(posedge clk) disable iff (!rst_ni)
    cmp_o |=> !cmp_o);

  // R6: disabling always drops the comparator out of the armed state
  assert_disable_disarms_R6 : assert property (@(posedge clk) disable iff (!rst_ni)
    !enable_i |=> state_q == SEQ_IDLE);
endmodule

// File: rtl/i2c_acmp_match.sv
module i2c_acmp_match
  import i2c_acmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = '0,
  localparam int unsigned BYTE_W = ADDR_W + 1
) (
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output acmp_match_t       match_o
);
  logic [ADDR_W-1:0] field;

  always_comb begin
    field             = rx_byte_i[BYTE_W-1:1];
    match_o.rw        = rx_byte_i[0];
    match_o.own_hit   = (field == own_addr_i);
    // a broadcast call is always a write
    match_o.bcast_hit = (field == BCAST_ADDR) && !rx_byte_i[0];
  end
endmodule

// File: rtl/i2c_acmp_flags.sv
module i2c_acmp_flags
  import i2c_acmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        cmp_i,
  input  acmp_match_t match_i,
  input  logic        self_master_i,
  input  logic        clr_addr_i,
  input  logic        clr_bcast_i,
  output logic        addressed_o,
  output logic        bcast_o,
  output logic        irq_o,
  output logic        ack_req_o,
  output logic        rw_o
);
  logic slave_hit;
  logic bcast_set;
  logic addressed_d, bcast_d, irq_d, ack_d, rw_d;
  logic rw_en;

  always_comb begin
    slave_hit   = cmp_i && (match_i.own_hit || match_i.bcast_hit) && !self_master_i;
    bcast_set   = cmp_i && match_i.bcast_hit;
    addressed_d = slave_hit || (addressed_o && !clr_addr_i);
    bcast_d     = bcast_set || (bcast_o && !clr_bcast_i);
    irq_d       = slave_hit;
    ack_d       = slave_hit;
    rw_en       = slave_hit;
    rw_d        = match_i.rw;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addressed_o <= 1'b0;
      bcast_o     <= 1'b0;
      irq_o       <= 1'b0;
      ack_req_o   <= 1'b0;
    end else begin
      addressed_o <= addressed_d;
      bcast_o     <= bcast_d;
      irq_o       <= irq_d;
      ack_req_o   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    rw_o <= 1'b0;
    else if (rw_en) rw_o <= rw_d;
  end

  assert_irq_single_R4 : assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_with_flag_R1 : assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> addressed_o);

  assert_addr_sticky_R3 : assert property (@(posedge clk) disable iff (!rst_ni)
    (addressed_o && !clr_addr_i) |=> addressed_o);

  assert_bcast_sticky_R3 : assert property (@(posedge clk) disable iff (!rst_ni)
    (bcast_o && !clr_bcast_i) |=> bcast_o);

  assert_rw_hold_R5 : assert property (@(posedge clk) disable iff (!rst_ni)
    !irq_d |=> $stable(rw_o));
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_acmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = '0,
  localparam int unsigned BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              self_master,
  input  logic              start_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              clr_addr,
  input  logic              clr_bcast,
  output logic              addressed,
  output logic              bcast_rcvd,
  output logic              irq,
  output logic              ack_req,
  output logic              rw_bit
);
  logic        rst_ni;
  logic        cmp;
  acmp_match_t match;

  i2c_acmp_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  i2c_acmp_seq u_seq (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .enable_i    (enable),
    .start_i     (start_det),
    .byte_done_i (byte_done),
    .cmp_o       (cmp)
  );

  i2c_acmp_match #(.ADDR_W(ADDR_W), .BCAST_ADDR(BCAST_ADDR)) u_match (
    .rx_byte_i  (rx_byte),
    .own_addr_i (own_addr),
    .match_o    (match)
  );

  i2c_acmp_flags u_flags (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .cmp_i         (cmp),
    .match_i       (match),
    .self_master_i (self_master),
    .clr_addr_i    (clr_addr),
    .clr_bcast_i   (clr_bcast),
    .addressed_o   (addressed),
    .bcast_o       (bcast_rcvd),
    .irq_o         (irq),
    .ack_req_o     (ack_req),
    .rw_o          (rw_bit)
  );

  assert_quiet_when_off_R6 : assert property (@(posedge clk) disable iff (!rst_ni)
    !enable |=> !irq && !ack_req);

  assert_master_no_ack_R8 : assert property (@(posedge clk) disable iff (!rst_ni)
    self_master |=> !irq && !ack_req);

  assert_ack_follows_irq_R4 : assert property (@(posedge clk) disable iff (!rst_ni)
    ack_req |-> irq);
endmodule

// File: tb/tb_i2c_addr_cmp.sv
module tb_i2c_addr_cmp;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, self_master = 1'b0, start_det = 1'b0, byte_done = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [6:0] own_addr = OWN;
  logic clr_addr = 1'b0, clr_bcast = 1'b0;
  logic addressed, bcast_rcvd, irq, ack_req, rw_bit;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [4:0] v;   // {addressed, bcast_rcvd, irq, ack_req, rw_bit}
    string      req;
  } exp_t;
  exp_t sb_q[$];

  // bench-side view of the requirements
  int   m_phase = 0;      // 0 idle, 1 armed, 2 data
  logic m_addr = 1'b0, m_bc = 1'b0, m_rw = 1'b0;

  always #5 clk = ~clk;

  i2c_addr_cmp dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .self_master(self_master),
    .start_det(start_det), .byte_done(byte_done), .rx_byte(rx_byte),
    .own_addr(own_addr), .clr_addr(clr_addr), .clr_bcast(clr_bcast),
    .addressed(addressed), .bcast_rcvd(bcast_rcvd), .irq(irq),
    .ack_req(ack_req), .rw_bit(rw_bit)
  );

  // monitor: compares outputs against queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if ({addressed, bcast_rcvd, irq, ack_req, rw_bit} !== e.v) begin
        fails++;
        $display("FAIL %s: {addr,bc,irq,ack,rw} actual %b expected %b",
                 e.req, {addressed, bcast_rcvd, irq, ack_req, rw_bit}, e.v);
      end
    end
  end

  // driver: one cycle of stimulus, then push the expected outputs
  task automatic step(input logic en, input logic mst, input logic st,
                      input logic bd, input logic [7:0] b,
                      input logic ca, input logic cb, input string req);
    logic cmp, own, bc, hit;
    exp_t e;
    @(negedge clk);
    enable = en; self_master = mst; start_det = st; byte_done = bd;
    rx_byte = b; clr_addr = ca; clr_bcast = cb;
    @(posedge clk);
    #1;
    cmp = en && (m_phase == 1) && bd && !st;
    own = (b[7:1] == own_addr);
    bc  = (b == 8'h00);
    hit = cmp && (own || bc) && !mst;
    m_addr = hit || (m_addr && !ca);
    m_bc   = (cmp && bc) || (m_bc && !cb);
    if (hit) m_rw = b[0];
    if (!en) m_phase = 0;
    else if (st) m_phase = 1;
    else if (m_phase == 1 && bd) m_phase = 2;
    e.v = {m_addr, m_bc, hit, hit, m_rw};
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(input logic en, input string req);
    step(en, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs during reset
    checks++;
    if ({addressed, bcast_rcvd, irq, ack_req, rw_bit} !== 5'b0) begin
      fails++;
      $display("FAIL R9: actual %b expected 00000", {addressed, bcast_rcvd, irq, ack_req, rw_bit});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: enabled mid-transfer, byte before any START ignored
    idle(1'b1, "R6 enable");
    step(1, 0, 0, 1, {OWN, 1'b0}, 0, 0, "R6 no start yet");
    // R1 / R4: direct hit
    step(1, 0, 1, 0, 8'h00, 0, 0, "R1 start");
    step(1, 0, 0, 1, {OWN, 1'b0}, 0, 0, "R1 own address hit");
    idle(1'b1, "R4 pulse ends");
    // R7: later byte of same transfer ignored
    step(1, 0, 0, 1, {OWN, 1'b1}, 0, 0, "R7 data byte ignored");
    step(1, 0, 0, 0, 8'h00, 1, 0, "R3 clear addressed");
    // R5: repeated start, read
    step(1, 0, 1, 0, 8'h00, 0, 0, "R5 repeated start");
    step(1, 0, 0, 1, {OWN, 1'b1}, 0, 0, "R5 read hit rw=1");
    idle(1'b1, "R5 rw held");
    // mismatch
    step(1, 0, 1, 0, 8'h00, 1, 0, "R1 start+clear");
    step(1, 0, 0, 1, {7'h5B, 1'b0}, 0, 0, "R1 mismatch");
    // R2: broadcast 0x00 and non-broadcast 0x01
    step(1, 0, 1, 0, 8'h00, 0, 0, "R2 start");
    step(1, 0, 0, 1, 8'h00, 0, 0, "R2 broadcast hit");
    step(1, 0, 0, 0, 8'h00, 1, 1, "R3 clear both");
    step(1, 0, 1, 0, 8'h00, 0, 0, "R2 start");
    step(1, 0, 0, 1, 8'h01, 0, 0, "R2 0x01 not broadcast");
    // R8: mastering
    step(1, 1, 1, 0, 8'h00, 0, 0, "R8 start as master");
    step(1, 1, 0, 1, 8'h00, 0, 0, "R8 broadcast while master");
    step(1, 1, 1, 0, 8'h00, 0, 1, "R8 start, clear bc");
    step(1, 1, 0, 1, {OWN, 1'b0}, 0, 0, "R8 own addr while master");
    // R6: disable, byte ignored, re-enable mid transfer
    step(0, 0, 1, 0, 8'h00, 0, 0, "R6 disabled start");
    step(0, 0, 0, 1, {OWN, 1'b0}, 0, 0, "R6 disabled byte");
    step(1, 0, 0, 1, {OWN, 1'b0}, 0, 0, "R6 re-enabled no start");
    step(1, 0, 1, 0, 8'h00, 0, 0, "R6 start after enable");
    step(1, 0, 0, 1, {OWN, 1'b0}, 0, 0, "R6 hit after start");
    // R7: start coincident with byte_done
    step(1, 0, 1, 1, {OWN, 1'b0}, 1, 0, "R7 start with byte");
    // R3: set and clear together, set wins
    step(1, 0, 0, 1, {OWN, 1'b0}, 1, 0, "R3 set beats clear");
    idle(1'b1, "R3 still set");
    @(negedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule